// File: doc/BRIEF.md
# Routed Interrupt Request Controller

This block watches a set of interrupt request lines (64 by default). For each source it keeps a request flag, an in-service flag, a mask bit and a trigger-mode bit. When a line changes in a way that matters, the block emits a routed event. Each event carries an 8-bit vector, looked up per source in a programmable table, and a level bit: 1 means raise, 0 means lower. Events leave one at a time on a valid/ready stream, to be consumed by a downstream interrupt distributor.

Software uses a 32-bit request/response register bus. Through it, software programs the mask, the trigger modes and a forwarding-enable word. It also clears latched edge requests, fills the vector table and reads an identification word. Unmasking, masking or clearing many sources with one write creates a batch of checks. The batch is walked from the lowest source index upward, one source per cycle, and each check may produce an event. New mask or clear writes and new input sampling wait until the batch has drained, so events never overtake one another.

Top module: `irq_route_ctrl`

## Requirements
- R1: When a source input rises, its request flag is set. If that source is unmasked, its in-service flag is set and a raise event (level 1) is sent, carrying the vector-table byte of that source.
- R2: When a source input falls and the source is in level mode (trigger bit 0), its request flag is cleared. If the in-service flag is set while the request flag is clear, the in-service flag is cleared and a lower event (level 0) is sent with the source's vector.
- R3: When a source input falls and the source is in edge mode (trigger bit 1), nothing happens. The request flag stays set and no event is sent. The trigger-mode word is at offset 0x060.
- R4: A write to the clear word (offset 0x080, write-only) acts only on sources that are written 1, are in edge mode and have their request flag set. Those request flags are cleared, and each such source then gets the lower check of R2.
- R5: A write to the mask word (offset 0x020, reset value all ones) compares the old and new bits. Bits that go from 1 to 0 get the raise check of R1. Bits that go from 0 to 1 get the lower check of R2. All raise checks run before any lower check.
- R6: Within a batch, sources are checked in ascending index order. One event is sent per valid/ready handshake. While ready is low, the event on the stream stays unchanged.
- R7: Each 64-bit word is reached as two 32-bit halves. Offset bit 2 selects the upper half, and a write to one half leaves the other half unchanged. The forwarding-enable word is at 0x040 and resets to 0. A response (rsp_valid) follows each accepted request by one cycle.
- R8: The vector byte of source i is at offset 0x200+i and resets to 0. Route bytes at 0x100+i always read 1, whatever is written to them.
- R9: The words at 0x0A0, 0x0C0 and 0x0E0 always read 0, and writes to them are ignored.
- R10: The identification word at 0x000 is read-only. Its lower half reads 0x00000007. Its upper half reads 0x001F0001: version 1 in bits 47:32 and the value 31 in bits 63:48.
- R11: While a batch is draining, mask and clear writes are held off (req_ready low) and input lines are not sampled. If a mask or clear write is accepted in the same cycle as an input change, the write's batch is produced first.
- R12: A request not aligned to its size gets an error response and changes no state. Size encodings are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is always an error. A request to an undecoded offset, a read of the clear word or a write of the identification word also gets an error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt request lines |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Access size code |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DATA_W | Read data |
| evt_valid | output | 1 | Routed event valid |
| evt_ready | input | 1 | Consumer takes the event |
| evt_vector | output | VEC_W | Event vector |
| evt_level | output | 1 | 1 = raise, 0 = lower |

## Verification
The two functions that can meet in one cycle are a software mask write and the sampling of a changed input line. The bench issues a mask write that unmasks a source with a latched request (source 10). On the same clock edge it raises a lower-indexed line (source 3) that the write also unmasks. If the write wins, the stream shows the vector of source 10 before that of source 3. If the input were taken first, the order would be reversed, so the observed order decides the outcome. Holding the consumer's ready low across a pending event checks separately that backpressure stalls the batch walk without losing or changing events.

// File: rtl/irc_pkg.sv
package irc_pkg;
   typedef enum logic [3:0] {
      RG_NONE, RG_ID, RG_MASK, RG_FWD, RG_EDGE, RG_CLR, RG_ZERO, RG_ROUTE, RG_VEC
   } region_e;
endpackage

// File: rtl/irc_bus_dec.sv
module irc_bus_dec
   import irc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SRC_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              write,
   output region_e           region,
   output logic              half,
   output logic [SRC_W-1:0]  idx,
   output logic              err
);
   logic       misalign;
   logic       hi_zero;
   logic [6:0] word;

   always_comb begin
      misalign = (size == 2'd3) || (size == 2'd1 && addr[0]) ||
                 (size == 2'd2 && addr[1:0] != 2'b00);
      hi_zero  = (addr[ADDR_W-1:10] == '0);
      word     = addr[9:3];
      half     = addr[2];
      idx      = addr[SRC_W-1:0];
      region   = RG_NONE;
      if (addr[9:6] == 4'b0100)      region = RG_ROUTE;
      else if (addr[9:6] == 4'b1000) region = RG_VEC;
      else if (addr[9:8] == 2'b00) begin
         case (word)
            7'd0:               region = write ? RG_NONE : RG_ID;
            7'd4:               region = RG_MASK;
            7'd8:               region = RG_FWD;
            7'd12:              region = RG_EDGE;
            7'd16:              region = write ? RG_CLR : RG_NONE;
            7'd20, 7'd24, 7'd28: region = RG_ZERO;
            default:            region = RG_NONE;
         endcase
      end
      err = misalign || !hi_zero || (region == RG_NONE);
   end
endmodule

// File: rtl/irc_first_set.sv
module irc_first_set #(
   parameter int N = 64,
   parameter int W = 6
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         any
);
   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end
endmodule

// File: rtl/irc_vec_table.sv
module irc_vec_table #(
   parameter int N  = 64,
   parameter int VW = 8,
   parameter int W  = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [W-1:0]  waddr,
   input  logic [VW-1:0] wdata,
   input  logic [W-1:0]  ra,
   output logic [VW-1:0] rd_a,
   input  logic [W-1:0]  rb,
   output logic [VW-1:0] rd_b
);
   logic [N-1:0][VW-1:0] ent;

   for (genvar g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                        ent[g] <= '0;
         else if (we && waddr == W'(g))     ent[g] <= wdata;
      end
   end

   assign rd_a = ent[ra];
   assign rd_b = ent[rb];
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irc_pkg::*;
#(
   parameter int          NSRC   = 64,
   parameter int          DATA_W = 32,
   parameter int          VEC_W  = 8,
   parameter int          ADDR_W = 12,
   parameter logic [15:0] ID_VER = 16'h0001,
   parameter logic [15:0] ID_CNT = 16'd31,
   parameter logic [31:0] ID_VAL = 32'h0000_0007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              evt_valid,
   input  logic              evt_ready,
   output logic [VEC_W-1:0]  evt_vector,
   output logic              evt_level
);
   localparam int SRC_W = $clog2(NSRC);

   if (DATA_W != 32)        begin : g_bad_dw  $error("DATA_W must be 32"); end
   if (NSRC != 2 * DATA_W)  begin : g_bad_ns  $error("NSRC must be two data words"); end
   if (VEC_W > DATA_W)      begin : g_bad_vw  $error("VEC_W wider than data"); end
   if (ADDR_W <= 10)        begin : g_bad_aw  $error("ADDR_W must exceed 10"); end

   function automatic logic [DATA_W-1:0] pick(input logic [NSRC-1:0] v, input logic h);
      return h ? v[NSRC-1:DATA_W] : v[DATA_W-1:0];
   endfunction
   function automatic logic [NSRC-1:0] place(input logic [DATA_W-1:0] w, input logic h);
      return h ? {w, {DATA_W{1'b0}}} : {{DATA_W{1'b0}}, w};
   endfunction

   logic [NSRC-1:0] src_q, irr_q, isr_q, mask_q, edge_q, fwd_q;
   logic [NSRC-1:0] batch_q, next_q;
   logic            lvl_q;

   region_e          dec_region;
   logic             dec_half, dec_err;
   logic [SRC_W-1:0] dec_idx;

   irc_bus_dec #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_dec (
      .addr(req_addr), .size(req_size), .write(req_write),
      .region(dec_region), .half(dec_half), .idx(dec_idx), .err(dec_err)
   );

   logic             busy, batch_req, acc, wr_ok, mask_wr, clr_wr, sample_en;
   assign busy      = (|batch_q) || (|next_q);
   assign batch_req = req_write && !dec_err &&
                      (dec_region == RG_MASK || dec_region == RG_CLR);
   assign req_ready = !(busy && batch_req);
   assign acc       = req_valid && req_ready;
   assign wr_ok     = acc && req_write && !dec_err;
   assign mask_wr   = wr_ok && dec_region == RG_MASK;
   assign clr_wr    = wr_ok && dec_region == RG_CLR;
   assign sample_en = !busy && !mask_wr && !clr_wr;

   // engine: lowest pending source of the current batch
   logic [SRC_W-1:0] cur_idx;
   logic             cur_any, step, hit;
   logic [VEC_W-1:0] tab_bus, tab_eng;

   irc_first_set #(.N(NSRC), .W(SRC_W)) u_first (
      .vec(batch_q), .idx(cur_idx), .any(cur_any)
   );

   irc_vec_table #(.N(NSRC), .VW(VEC_W), .W(SRC_W)) u_tab (
      .clk(clk), .rst_n(rst_n),
      .we(wr_ok && dec_region == RG_VEC), .waddr(dec_idx), .wdata(req_wdata[VEC_W-1:0]),
      .ra(dec_idx), .rd_a(tab_bus), .rb(cur_idx), .rd_b(tab_eng)
   );

   assign step = cur_any && (!evt_valid || evt_ready);
   assign hit  = lvl_q ? (irr_q[cur_idx] && !mask_q[cur_idx])
                       : (isr_q[cur_idx] && !irr_q[cur_idx]);

   // batch load: first part is raise checks, second part lower checks
   logic [NSRC-1:0] ld_first, ld_second, irr_upd, mask_upd, rise, lows;
   logic            do_load;

   always_comb begin
      rise      = src_i & ~src_q;
      lows      = ~src_i & src_q & ~edge_q;
      ld_first  = '0;
      ld_second = '0;
      do_load   = 1'b0;
      irr_upd   = irr_q;
      mask_upd  = mask_q;
      if (mask_wr) begin
         mask_upd  = (mask_q & ~place({DATA_W{1'b1}}, dec_half)) | place(req_wdata, dec_half);
         ld_first  = mask_q & ~mask_upd;
         ld_second = ~mask_q & mask_upd;
         do_load   = 1'b1;
      end else if (clr_wr) begin
         ld_second = irr_q & edge_q & place(req_wdata, dec_half);
         irr_upd   = irr_q & ~ld_second;
         do_load   = 1'b1;
      end else if (sample_en) begin
         ld_first  = rise;
         ld_second = lows;
         irr_upd   = (irr_q | rise) & ~lows;
         do_load   = |(rise | lows);
      end
   end

   logic [DATA_W-1:0] rd_word;
   always_comb begin
      case (dec_region)
         RG_ID:    rd_word = dec_half ? {ID_CNT, ID_VER} : ID_VAL;
         RG_MASK:  rd_word = pick(mask_q, dec_half);
         RG_FWD:   rd_word = pick(fwd_q, dec_half);
         RG_EDGE:  rd_word = pick(edge_q, dec_half);
         RG_ROUTE: rd_word = DATA_W'(1);
         RG_VEC:   rd_word = DATA_W'(tab_bus);
         default:  rd_word = '0;
      endcase
   end

   logic [NSRC-1:0] rest;
   assign rest = batch_q & ~(NSRC'(1) << cur_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;  irr_q <= '0;  isr_q <= '0;  mask_q <= '1;
         edge_q <= '0; fwd_q <= '0;  batch_q <= '0; next_q <= '0; lvl_q <= 1'b0;
         evt_valid <= 1'b0; evt_vector <= '0; evt_level <= 1'b0;
         rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
      end else begin
         if (sample_en) src_q <= src_i;
         irr_q  <= irr_upd;
         mask_q <= mask_upd;
         if (do_load) begin
            if (|ld_first) begin
               batch_q <= ld_first;  lvl_q <= 1'b1; next_q <= ld_second;
            end else begin
               batch_q <= ld_second; lvl_q <= 1'b0; next_q <= '0;
            end
         end else if (step) begin
            if (rest == '0) begin
               batch_q <= next_q; lvl_q <= 1'b0; next_q <= '0;
            end else begin
               batch_q <= rest;
            end
         end
         if (step && hit) begin
            isr_q[cur_idx] <= lvl_q;
            evt_valid      <= 1'b1;
            evt_vector     <= tab_eng;
            evt_level      <= lvl_q;
         end else if (evt_ready) begin
            evt_valid <= 1'b0;
         end
         if (wr_ok && dec_region == RG_EDGE)
            edge_q <= (edge_q & ~place({DATA_W{1'b1}}, dec_half)) | place(req_wdata, dec_half);
         if (wr_ok && dec_region == RG_FWD)
            fwd_q <= (fwd_q & ~place({DATA_W{1'b1}}, dec_half)) | place(req_wdata, dec_half);
         rsp_valid <= acc;
         rsp_err   <= acc && dec_err;
         rsp_rdata <= (acc && !req_write && !dec_err) ? rd_word : '0;
      end
   end

   // R6: a stalled event is held unchanged
   assert_evt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !evt_ready |=> evt_valid && $stable(evt_vector) && $stable(evt_level));

   // R6: the walk touches at most one in-service flag per cycle
   assert_isr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(isr_q ^ $past(isr_q)) <= 1);

   // R7: every accepted request is answered next cycle
   assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);

   // R12: an error request leaves the programmable state alone
   assert_err_no_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && dec_err |=> $stable(mask_q) && $stable(edge_q) && $stable(fwd_q));

   // R3: an edge-mode request flag is dropped only by a clear write
   assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      |($past(irr_q & edge_q) & ~irr_q) |-> $past(clr_wr));
endmodule

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NSTEP = 14;
   // {kind[1:0], pad, half, data[63:0]}; kind 0=inputs 1=mask 2=clear 3=trigger mode
   localparam logic [67:0] STEPS [NSTEP] = '{
      {2'd3, 2'b00, 64'h0000_0000_0000_00F0},
      {2'd1, 2'b00, 64'h0000_0000_0000_0000},
      {2'd0, 2'b00, 64'h0000_0000_0000_0013},
      {2'd0, 2'b00, 64'h0000_0000_0000_0002},
      {2'd2, 2'b00, 64'h0000_0000_0000_0013},
      {2'd0, 2'b00, 64'h0000_0001_0000_0002},
      {2'd1, 2'b01, 64'h0000_0000_FFFF_FFFE},
      {2'd1, 2'b00, 64'h0000_0000_0000_0002},
      {2'd0, 2'b00, 64'h0000_0001_0000_0000},
      {2'd1, 2'b00, 64'h0000_0000_0000_0000},
      {2'd0, 2'b00, 64'h8000_0001_0000_00F0},
      {2'd1, 2'b01, 64'h0000_0000_7FFF_FFFE},
      {2'd0, 2'b00, 64'h0000_0001_0000_0108},
      {2'd2, 2'b00, 64'h0000_0000_0000_00FF}
   };

   logic        clk = 0, rst_n = 0;
   logic [63:0] src = '0;
   logic        req_valid = 0, req_ready, req_write = 0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        evt_valid, evt_ready = 1, evt_level;
   logic [7:0]  evt_vector;

   irq_route_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .evt_valid(evt_valid), .evt_ready(evt_ready),
      .evt_vector(evt_vector), .evt_level(evt_level)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [8:0] got_q[$], exp_q[$];
   logic [63:0] m_irr = '0, m_isr = '0, m_mask = '1, m_edge = '0, m_src = '0;

   always @(negedge clk)
      if (rst_n && evt_valid && evt_ready) got_q.push_back({evt_level, evt_vector});

   function automatic logic [7:0] vec_of(input int i);
      return 8'(i) ^ 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic bus(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] d, output logic [31:0] rd, output logic er);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 0;
      rd = rsp_rdata; er = rsp_err;
   endtask

   // reference model, written from the requirements
   task automatic m_check(input int i, input bit lvl);
      if (lvl) begin
         if (m_irr[i] && !m_mask[i]) begin m_isr[i] = 1; exp_q.push_back({1'b1, vec_of(i)}); end
      end else begin
         if (m_isr[i] && !m_irr[i]) begin m_isr[i] = 0; exp_q.push_back({1'b0, vec_of(i)}); end
      end
   endtask
   task automatic m_inputs(input logic [63:0] n);
      logic [63:0] r, f;
      r = n & ~m_src; f = ~n & m_src & ~m_edge;
      m_irr = (m_irr | r) & ~f; m_src = n;
      for (int i = 0; i < 64; i++) if (r[i]) m_check(i, 1);
      for (int i = 0; i < 64; i++) if (f[i]) m_check(i, 0);
   endtask
   task automatic m_maskw(input bit h, input logic [31:0] d);
      logic [63:0] nm, up, dn;
      nm = h ? {d, m_mask[31:0]} : {m_mask[63:32], d};
      up = m_mask & ~nm; dn = ~m_mask & nm; m_mask = nm;
      for (int i = 0; i < 64; i++) if (up[i]) m_check(i, 1);
      for (int i = 0; i < 64; i++) if (dn[i]) m_check(i, 0);
   endtask
   task automatic m_clear(input bit h, input logic [31:0] d);
      logic [63:0] c;
      c = m_irr & m_edge & (h ? {d, 32'h0} : {32'h0, d});
      m_irr = m_irr & ~c;
      for (int i = 0; i < 64; i++) if (c[i]) m_check(i, 0);
   endtask

   task automatic drain_cmp(input string req);
      repeat (200) @(negedge clk);
      chk(got_q.size() == exp_q.size(), {req, " event count"}, 64'(got_q.size()), 64'(exp_q.size()));
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
         chk(got_q[i] == exp_q[i], {req, " event"}, 64'(got_q[i]), 64'(exp_q[i]));
      got_q.delete(); exp_q.delete();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      logic er;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(evt_valid == 0, "R6 reset evt_valid", 64'(evt_valid), 0);
      chk(req_ready == 1, "R11 reset req_ready", 64'(req_ready), 1);
      bus(0, 12'h020, 2, 0, rd, er); chk(rd == 32'hFFFF_FFFF && !er, "R5 mask reset low", 64'(rd), 64'hFFFF_FFFF);
      bus(0, 12'h024, 2, 0, rd, er); chk(rd == 32'hFFFF_FFFF, "R5 mask reset high", 64'(rd), 64'hFFFF_FFFF);
      bus(0, 12'h040, 2, 0, rd, er); chk(rd == 0, "R7 fwd reset", 64'(rd), 0);
      // identification
      bus(0, 12'h000, 2, 0, rd, er); chk(rd == 32'h7 && !er, "R10 id low", 64'(rd), 7);
      bus(0, 12'h004, 2, 0, rd, er); chk(rd == 32'h001F_0001, "R10 id high", 64'(rd), 64'h001F_0001);
      bus(1, 12'h000, 2, 0, rd, er); chk(er == 1, "R12 id write error", 64'(er), 1);
      // half isolation
      bus(1, 12'h064, 2, 32'hA5A5_A5A5, rd, er);
      bus(0, 12'h060, 2, 0, rd, er); chk(rd == 0, "R7 other half kept", 64'(rd), 0);
      bus(0, 12'h064, 2, 0, rd, er); chk(rd == 32'hA5A5_A5A5, "R7 upper half", 64'(rd), 64'hA5A5_A5A5);
      bus(1, 12'h064, 2, 0, rd, er);
      bus(1, 12'h040, 2, 32'h0000_1234, rd, er);
      bus(0, 12'h040, 2, 0, rd, er); chk(rd == 32'h1234, "R7 fwd readback", 64'(rd), 64'h1234);
      // fixed words and route bytes
      bus(1, 12'h0A0, 2, 32'hFFFF_FFFF, rd, er);
      bus(0, 12'h0A0, 2, 0, rd, er); chk(rd == 0 && !er, "R9 fixed zero", 64'(rd), 0);
      bus(0, 12'h0C4, 2, 0, rd, er); chk(rd == 0 && !er, "R9 auto zero", 64'(rd), 0);
      bus(1, 12'h105, 0, 0, rd, er);
      bus(0, 12'h105, 0, 0, rd, er); chk(rd == 1 && !er, "R8 route byte", 64'(rd), 1);
      // errors
      bus(1, 12'h022, 2, 0, rd, er); chk(er == 1, "R12 unaligned error", 64'(er), 1);
      bus(0, 12'h020, 2, 0, rd, er); chk(rd == 32'hFFFF_FFFF, "R12 unaligned no change", 64'(rd), 64'hFFFF_FFFF);
      bus(0, 12'h300, 2, 0, rd, er); chk(er == 1, "R12 undecoded", 64'(er), 1);
      bus(0, 12'h080, 2, 0, rd, er); chk(er == 1, "R12 clear read", 64'(er), 1);
      bus(0, 12'h020, 2'd3, 0, rd, er); chk(er == 1, "R12 size 3", 64'(er), 1);
      // vector table
      for (int i = 0; i < 64; i++) bus(1, 12'h200 + 12'(i), 0, 32'(vec_of(i)), rd, er);
      bus(0, 12'h205, 0, 0, rd, er); chk(rd == 32'(vec_of(5)), "R8 vector readback", 64'(rd), 64'(vec_of(5)));

      // table walk
      for (int s = 0; s < NSTEP; s++) begin
         logic [1:0] kind;
         logic h;
         logic [63:0] d;
         kind = STEPS[s][67:66]; h = STEPS[s][64]; d = STEPS[s][63:0];
         case (kind)
            2'd0: begin @(negedge clk); src = d; m_inputs(d); drain_cmp("R1 R2 R3 R6 inputs"); end
            2'd1: begin bus(1, h ? 12'h024 : 12'h020, 2, d[31:0], rd, er); m_maskw(h, d[31:0]);
                        drain_cmp("R5 R6 mask"); end
            2'd2: begin bus(1, h ? 12'h084 : 12'h080, 2, d[31:0], rd, er); m_clear(h, d[31:0]);
                        drain_cmp("R4 clear"); end
            default: begin bus(1, h ? 12'h064 : 12'h060, 2, d[31:0], rd, er);
                        m_edge = h ? {d[31:0], m_edge[31:0]} : {m_edge[63:32], d[31:0]};
                        drain_cmp("R3 mode"); end
         endcase
      end

      // collision: mask write and input change in the same cycle (R11)
      @(negedge clk); src = '0; m_inputs('0); drain_cmp("R2 setup");
      bus(1, 12'h020, 2, 32'hFFFF_FFFF, rd, er); m_maskw(0, 32'hFFFF_FFFF); drain_cmp("R5 setup");
      @(negedge clk); src = 64'h400; m_inputs(64'h400); drain_cmp("R1 masked");
      fork
         begin @(negedge clk); src = 64'h408; end
         bus(1, 12'h020, 2, 32'hFFFF_FBF7, rd, er);
      join
      m_maskw(0, 32'hFFFF_FBF7); m_inputs(64'h408);
      chk(exp_q.size() == 2 && exp_q[0] == {1'b1, vec_of(10)}, "R11 model order", 64'(exp_q.size()), 2);
      drain_cmp("R11 collision");

      // backpressure (R6)
      evt_ready = 0;
      @(negedge clk); src = 64'h400; m_inputs(64'h400);
      repeat (10) @(negedge clk);
      chk(evt_valid == 1, "R6 held valid", 64'(evt_valid), 1);
      chk(evt_vector == vec_of(3) && evt_level == 0, "R6 held event",
          64'({evt_level, evt_vector}), 64'({1'b0, vec_of(3)}));
      @(negedge clk); evt_ready = 1;
      drain_cmp("R2 R6 release");

      finish_run();
   end
endmodule